// File: doc/BRIEF.md
# SPI NAND Page Access Sequencer

This block sits between a storage controller and a serial-flash operation engine. It takes one high-level request at a time (read a page, program a page, erase a block, or unlock the whole array) together with a row address and a column address, and expands it into the ordered series of serial NAND operations the device needs. Each operation goes to the engine as a descriptor: opcode, address, address length, dummy length, data lane count, data direction and a one-byte write value. The engine returns a completion pulse and, for status reads, the status byte.

Every array access is split in two. A command moves data between the array and the on-die cache, and a cache transfer command moves it to or from the host. Between the array step and the final result, the sequencer polls the status feature register until the busy bit clears, giving up after a programmable number of reads. The status byte is then decoded into an ECC outcome (for reads) or a failure flag (for program and erase), and a one-cycle done pulse carries a result code.

Top module: `nps_page_seq`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and op_valid is 0.
- R2: A request is taken only on a cycle where req_valid and req_ready are both 1; req_ready is 0 from the next cycle until done, and req_valid while it is 0 has no effect on the descriptor stream or results.
- R3: A read (req_kind 0) issues opcode 0x13 with the row address (3 bytes, no data), then status polls, then opcode 0x03 with the column address (2 bytes, zero dummy bytes, 1 data lane, data in).
- R4: A status poll is opcode 0x0F, address 0xC0 (1 byte), 1 lane, data in; it is repeated while status bit 0 is 1.
- R5: For a read, status bits [5:4] decide the result: 0 gives OK (code 0), 1 gives CORRECTED (code 1), 2 or 3 give UNCORRECTABLE (code 2); the cache transfer is still issued.
- R6: A program (req_kind 1) issues 0x06 (no address), then 0x02 with the column (2 bytes, 1 lane, data out), then 0x10 with the row (3 bytes), then polls; status bit 3 gives PROG_FAIL (code 3), otherwise OK.
- R7: An erase (req_kind 2) issues 0x06, then 0xD8 with the row (3 bytes), then polls; status bit 2 gives ERASE_FAIL (code 4), otherwise OK, and bit 3 is ignored.
- R8: An unlock (req_kind 3) issues a single 0x1F with address 0xA0 (1 byte), 1 lane, data out, write value 0x00, and reports OK.
- R9: The poll phase makes at most max(poll_limit, 1) status reads; if all of them see bit 0 set, the result is TIMEOUT (code 5) and no further operation is issued.
- R10: done is high for exactly one cycle, on the cycle after the final operation's op_done, with result valid on that cycle and req_ready already 1.
- R11: A descriptor is held stable while op_valid is 1 until op_done; each op_done completes exactly one operation, and the unaddressed fields (address, lanes, write value) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 read, 1 program, 2 erase, 3 unlock |
| req_row | input | ROW_BYTES*8 | Page/block row address |
| req_col | input | COL_BYTES*8 | Column address within the page |
| poll_limit | input | POLL_W | Maximum number of status reads per poll phase |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| op_valid | output | 1 | Descriptor presented to the engine |
| op_opcode | output | 8 | Operation opcode |
| op_addr | output | ROW_BYTES*8 | Operation address, right-aligned |
| op_addr_nbytes | output | 3 | Number of address bytes |
| op_dummy_nbytes | output | 2 | Number of dummy bytes |
| op_data_lanes | output | 3 | Data lanes (0 when no data phase) |
| op_data_dir | output | 2 | 0 none, 1 in, 2 out |
| op_wdata | output | 8 | Single-byte write value for feature writes |
| op_done | input | 1 | Engine finished the presented operation |
| op_rdata | input | 8 | Status byte returned with op_done |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code, valid with done |

## Verification
The assertions take for granted that the engine raises op_done only while op_valid is high, for a single cycle, and that op_rdata is meaningful on that cycle. The bench's engine model honours this: it waits a fixed latency after a descriptor appears, pulses op_done once, drops it on the following cycle, and hands out scripted status bytes only on status polls. Requests are driven only on falling edges, and stray requests during a sequence are raised deliberately to probe R2.

// File: rtl/nps_pkg.sv
package nps_pkg;
   typedef enum logic [1:0] {
      K_READ   = 2'd0,
      K_PROG   = 2'd1,
      K_ERASE  = 2'd2,
      K_UNLOCK = 2'd3
   } kind_e;

   typedef enum logic [2:0] {
      RES_OK     = 3'd0,
      RES_CORR   = 3'd1,
      RES_UNCORR = 3'd2,
      RES_PFAIL  = 3'd3,
      RES_EFAIL  = 3'd4,
      RES_TOUT   = 3'd5
   } res_e;

   typedef enum logic [3:0] {
      S_IDLE, S_WREN, S_ARRAY_RD, S_PROG_LOAD, S_PROG_EXEC,
      S_ERASE, S_POLL, S_CACHE_RD, S_UNLOCK
   } step_e;

   localparam logic [7:0] OPC_WREN     = 8'h06;
   localparam logic [7:0] OPC_ARRAY_RD = 8'h13;
   localparam logic [7:0] OPC_GETF     = 8'h0F;
   localparam logic [7:0] OPC_SETF     = 8'h1F;
   localparam logic [7:0] OPC_PLOAD    = 8'h02;
   localparam logic [7:0] OPC_PEXEC    = 8'h10;
   localparam logic [7:0] OPC_ERASE    = 8'hD8;
   localparam logic [7:0] FA_STATUS    = 8'hC0;
   localparam logic [7:0] FA_LOCK      = 8'hA0;

   localparam logic [1:0] DIR_NONE = 2'd0;
   localparam logic [1:0] DIR_IN   = 2'd1;
   localparam logic [1:0] DIR_OUT  = 2'd2;
endpackage

// File: rtl/nps_desc_gen.sv
module nps_desc_gen #(
   parameter int ROW_BYTES = 3,
   parameter int COL_BYTES = 2,
   parameter int READ_MODE = 0,
   localparam int ROW_W  = 8 * ROW_BYTES,
   localparam int COL_W  = 8 * COL_BYTES,
   localparam int ADDR_W = ROW_W
) (
   input  nps_pkg::step_e     step,
   input  logic [ROW_W-1:0]   row,
   input  logic [COL_W-1:0]   col,
   output logic [7:0]         opcode,
   output logic [ADDR_W-1:0]  addr,
   output logic [2:0]         addr_nbytes,
   output logic [1:0]         dummy_nbytes,
   output logic [2:0]         lanes,
   output logic [1:0]         dir,
   output logic [7:0]         wdata
);
   import nps_pkg::*;

   logic [7:0] rd_op;
   logic [1:0] rd_dum;
   logic [2:0] rd_lanes;

   generate
      if (READ_MODE == 0) begin : g_rd_plain
         assign rd_op = 8'h03;  assign rd_dum = 2'd0;  assign rd_lanes = 3'd1;
      end else if (READ_MODE == 1) begin : g_rd_fast
         assign rd_op = 8'h0B;  assign rd_dum = 2'd1;  assign rd_lanes = 3'd1;
      end else begin : g_rd_quad
         assign rd_op = 8'h6B;  assign rd_dum = 2'd1;  assign rd_lanes = 3'd4;
      end
   endgenerate

   localparam logic [2:0] NB_ROW = 3'(ROW_BYTES);
   localparam logic [2:0] NB_COL = 3'(COL_BYTES);

   always_comb begin
      opcode       = 8'h00;
      addr         = '0;
      addr_nbytes  = 3'd0;
      dummy_nbytes = 2'd0;
      lanes        = 3'd0;
      dir          = DIR_NONE;
      wdata        = 8'h00;
      unique case (step)
         S_WREN:      opcode = OPC_WREN;
         S_ARRAY_RD:  begin opcode = OPC_ARRAY_RD; addr = row; addr_nbytes = NB_ROW; end
         S_PROG_EXEC: begin opcode = OPC_PEXEC;    addr = row; addr_nbytes = NB_ROW; end
         S_ERASE:     begin opcode = OPC_ERASE;    addr = row; addr_nbytes = NB_ROW; end
         S_PROG_LOAD: begin
            opcode = OPC_PLOAD; addr = ADDR_W'(col); addr_nbytes = NB_COL;
            lanes = 3'd1; dir = DIR_OUT;
         end
         S_CACHE_RD: begin
            opcode = rd_op; addr = ADDR_W'(col); addr_nbytes = NB_COL;
            dummy_nbytes = rd_dum; lanes = rd_lanes; dir = DIR_IN;
         end
         S_POLL: begin
            opcode = OPC_GETF; addr = ADDR_W'(FA_STATUS); addr_nbytes = 3'd1;
            lanes = 3'd1; dir = DIR_IN;
         end
         S_UNLOCK: begin
            opcode = OPC_SETF; addr = ADDR_W'(FA_LOCK); addr_nbytes = 3'd1;
            lanes = 3'd1; dir = DIR_OUT; wdata = 8'h00;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/nps_status_dec.sv
module nps_status_dec (
   input  logic [7:0]     status,
   input  nps_pkg::kind_e kind,
   output logic           busy,
   output nps_pkg::res_e  res
);
   import nps_pkg::*;

   assign busy = status[0];

   always_comb begin
      res = RES_OK;
      unique case (kind)
         K_READ: begin
            unique case (status[5:4])
               2'd0:    res = RES_OK;
               2'd1:    res = RES_CORR;
               default: res = RES_UNCORR;
            endcase
         end
         K_PROG:  if (status[3]) res = RES_PFAIL;
         K_ERASE: if (status[2]) res = RES_EFAIL;
         default: res = RES_OK;
      endcase
   end
endmodule

// File: rtl/nps_poll_ctr.sv
module nps_poll_ctr #(
   parameter int POLL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   input  logic [POLL_W-1:0] limit,
   output logic              last
);
   logic [POLL_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (inc)  cnt <= cnt + 1'b1;
   end

   assign last = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};
endmodule

// File: rtl/nps_page_seq.sv
module nps_page_seq #(
   parameter int ROW_BYTES = 3,
   parameter int COL_BYTES = 2,
   parameter int POLL_W    = 16,
   parameter int READ_MODE = 0,
   localparam int ROW_W  = 8 * ROW_BYTES,
   localparam int COL_W  = 8 * COL_BYTES,
   localparam int ADDR_W = ROW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic [POLL_W-1:0] poll_limit,
   output logic              req_ready,
   output logic              op_valid,
   output logic [7:0]        op_opcode,
   output logic [ADDR_W-1:0] op_addr,
   output logic [2:0]        op_addr_nbytes,
   output logic [1:0]        op_dummy_nbytes,
   output logic [2:0]        op_data_lanes,
   output logic [1:0]        op_data_dir,
   output logic [7:0]        op_wdata,
   input  logic              op_done,
   input  logic [7:0]        op_rdata,
   output logic              done,
   output logic [2:0]        result
);
   import nps_pkg::*;

   generate
      if (ROW_BYTES < 1 || ROW_BYTES > 4) begin : g_bad_row
         $error("ROW_BYTES must lie in 1..4");
      end
      if (COL_BYTES < 1 || COL_BYTES > ROW_BYTES) begin : g_bad_col
         $error("COL_BYTES must lie in 1..ROW_BYTES");
      end
      if (READ_MODE < 0 || READ_MODE > 2) begin : g_bad_mode
         $error("READ_MODE must be 0, 1 or 2");
      end
      if (POLL_W < 1) begin : g_bad_poll
         $error("POLL_W must be positive");
      end
   endgenerate

   step_e             state;
   kind_e             kind_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   res_e              ecc_q;
   res_e              result_q;
   logic              done_q;

   logic  st_busy;
   res_e  st_res;
   logic  poll_last;
   logic  accept;

   assign accept    = req_valid && (state == S_IDLE);
   assign req_ready = (state == S_IDLE);
   assign op_valid  = (state != S_IDLE);
   assign done      = done_q;
   assign result    = result_q;

   nps_desc_gen #(
      .ROW_BYTES (ROW_BYTES),
      .COL_BYTES (COL_BYTES),
      .READ_MODE (READ_MODE)
   ) u_desc (
      .step         (state),
      .row          (row_q),
      .col          (col_q),
      .opcode       (op_opcode),
      .addr         (op_addr),
      .addr_nbytes  (op_addr_nbytes),
      .dummy_nbytes (op_dummy_nbytes),
      .lanes        (op_data_lanes),
      .dir          (op_data_dir),
      .wdata        (op_wdata)
   );

   nps_status_dec u_dec (
      .status (op_rdata),
      .kind   (kind_q),
      .busy   (st_busy),
      .res    (st_res)
   );

   nps_poll_ctr #(.POLL_W(POLL_W)) u_poll (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state == S_IDLE),
      .inc   (op_done && state == S_POLL && st_busy),
      .limit (poll_limit),
      .last  (poll_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         kind_q   <= K_READ;
         row_q    <= '0;
         col_q    <= '0;
         ecc_q    <= RES_OK;
         result_q <= RES_OK;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (state == S_IDLE) begin
            if (accept) begin
               kind_q <= kind_e'(req_kind);
               row_q  <= req_row;
               col_q  <= req_col;
               ecc_q  <= RES_OK;
               unique case (kind_e'(req_kind))
                  K_READ:   state <= S_ARRAY_RD;
                  K_UNLOCK: state <= S_UNLOCK;
                  default:  state <= S_WREN;
               endcase
            end
         end else if (op_done) begin
            unique case (state)
               S_WREN:      state <= (kind_q == K_PROG) ? S_PROG_LOAD : S_ERASE;
               S_PROG_LOAD: state <= S_PROG_EXEC;
               S_ARRAY_RD,
               S_PROG_EXEC,
               S_ERASE:     state <= S_POLL;
               S_POLL: begin
                  if (st_busy) begin
                     if (poll_last) begin
                        state    <= S_IDLE;
                        done_q   <= 1'b1;
                        result_q <= RES_TOUT;
                     end
                  end else if (kind_q == K_READ) begin
                     ecc_q <= st_res;
                     state <= S_CACHE_RD;
                  end else begin
                     state    <= S_IDLE;
                     done_q   <= 1'b1;
                     result_q <= st_res;
                  end
               end
               S_CACHE_RD: begin
                  state    <= S_IDLE;
                  done_q   <= 1'b1;
                  result_q <= ecc_q;
               end
               S_UNLOCK: begin
                  state    <= S_IDLE;
                  done_q   <= 1'b1;
                  result_q <= RES_OK;
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/nps_chk.sv
module nps_chk #(
   parameter int AW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          op_valid,
   input logic [7:0]    op_opcode,
   input logic [AW-1:0] op_addr,
   input logic [2:0]    op_addr_nbytes,
   input logic          op_done,
   input logic          done,
   input logic [2:0]    result
);
   assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   assert_no_op_while_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !op_valid);

   assert_poll_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_opcode == 8'h0F |-> op_addr[7:0] == 8'hC0 && op_addr_nbytes == 3'd1);

   assert_desc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !op_done |=> op_valid && $stable(op_opcode) && $stable(op_addr));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> result <= 3'd5 && req_ready);

   assert_timeout_after_poll_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done && result == 3'd5 |-> $past(op_opcode) == 8'h0F && $past(op_done));
endmodule

bind nps_page_seq nps_chk #(.AW(ADDR_W)) u_chk (.*);

// File: tb/sim_nps_page_seq.sv
module sim_nps_page_seq;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic [23:0] req_row = '0;
   logic [15:0] req_col = '0;
   logic [15:0] poll_limit = 16'd8;
   logic        req_ready, op_valid, done;
   logic [7:0]  op_opcode, op_wdata;
   logic [23:0] op_addr;
   logic [2:0]  op_addr_nbytes, op_data_lanes, result;
   logic [1:0]  op_dummy_nbytes, op_data_dir;
   logic        op_done = 1'b0;
   logic [7:0]  op_rdata = 8'h00;

   int n_tests = 0, n_fail = 0, n_done = 0, eng_cnt = 0, cyc = 0;
   logic prev_done = 1'b0;

   logic [63:0] exp_q[$];
   string       tag_q[$];
   logic [2:0]  res_q[$];
   string       rtag_q[$];
   logic [7:0]  stat_q[$];

   always #10 clk = ~clk;

   nps_page_seq u0 (.*);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] d(input logic [7:0] opc, input logic [23:0] a,
                                     input logic [2:0] nab, input logic [1:0] ndum,
                                     input logic [2:0] ln, input logic [1:0] dr,
                                     input logic [7:0] wd);
      return {14'd0, opc, a, nab, ndum, ln, dr, wd};
   endfunction

   function automatic logic [63:0] cur_desc();
      return d(op_opcode, op_addr, op_addr_nbytes, op_dummy_nbytes,
               op_data_lanes, op_data_dir, op_wdata);
   endfunction

   // expected descriptors, computed from the requirement text
   function automatic logic [63:0] poll_d();   return d(8'h0F, 24'hC0, 3'd1, 2'd0, 3'd1, 2'd1, 8'h00); endfunction
   function automatic logic [63:0] wren_d();   return d(8'h06, 24'h0, 3'd0, 2'd0, 3'd0, 2'd0, 8'h00); endfunction

   task automatic push_op(input logic [63:0] v, input string tag);
      exp_q.push_back(v); tag_q.push_back(tag);
   endtask

   task automatic push_polls(input int n_busy, input logic [7:0] final_stat, input string tag);
      for (int i = 0; i < n_busy; i++) begin
         push_op(poll_d(), tag); stat_q.push_back(8'h01);
      end
      push_op(poll_d(), tag); stat_q.push_back(final_stat);
   endtask

   task automatic issue(input logic [1:0] kind, input logic [23:0] row,
                        input logic [15:0] col, input bit stray);
      int target;
      target = n_done + 1;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_row = row; req_col = col;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 ready low after accept", {63'd0, req_ready}, 64'd0);
      if (stray) begin
         for (int k = 0; k < 4; k++) begin
            req_valid = 1'b1; req_kind = 2'd2; req_row = 24'hFFFFFF; req_col = 16'hFFFF;
            @(negedge clk);
            chk("R2 ready stays low", {63'd0, req_ready}, 64'd0);
         end
         req_valid = 1'b0;
      end
      while (n_done < target) @(negedge clk);
   endtask

   // engine model and descriptor scoreboard
   always @(negedge clk) begin
      if (!rst_n) begin
         op_done = 1'b0; eng_cnt = 0;
      end else if (op_done) begin
         op_done = 1'b0; eng_cnt = 0;
      end else if (op_valid) begin
         if (eng_cnt == 0) begin
            if (exp_q.size() == 0) begin
               n_tests++; n_fail++;
               $display("FAIL R11 unexpected op actual=%h expected=none", cur_desc());
            end else begin
               chk(tag_q.pop_front(), cur_desc(), exp_q.pop_front());
            end
         end
         eng_cnt++;
         if (eng_cnt == LAT) begin
            op_done = 1'b1;
            op_rdata = 8'h00;
            if (op_opcode == 8'h0F && stat_q.size() > 0) op_rdata = stat_q.pop_front();
         end
      end
   end

   // result monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            if (res_q.size() == 0) begin
               n_tests++; n_fail++;
               $display("FAIL R10 unexpected done actual=%0d expected=none", result);
            end else begin
               chk(rtag_q.pop_front(), {61'd0, result}, {61'd0, res_q.pop_front()});
            end
            chk("R10 ready with done", {63'd0, req_ready}, 64'd1);
            if (prev_done) chk("R10 done single cycle", 64'd1, 64'd0);
            n_done++;
         end
         prev_done = done;
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<100000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic do_read(input logic [23:0] row, input logic [15:0] col, input int busy_n,
                          input logic [7:0] st, input logic [2:0] exp_res, input string tag,
                          input bit stray);
      push_op(d(8'h13, row, 3'd3, 2'd0, 3'd0, 2'd0, 8'h00), "R3 array read");
      push_polls(busy_n, st, "R4 poll");
      push_op(d(8'h03, {8'h00, col}, 3'd2, 2'd0, 3'd1, 2'd1, 8'h00), "R3 cache read");
      res_q.push_back(exp_res); rtag_q.push_back(tag);
      issue(2'd0, row, col, stray);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ready at reset", {63'd0, req_ready}, 64'd1);
      chk("R1 done at reset", {63'd0, done}, 64'd0);
      chk("R1 op_valid at reset", {63'd0, op_valid}, 64'd0);
      rst_n = 1'b1;

      // R8 unlock
      push_op(d(8'h1F, 24'hA0, 3'd1, 2'd0, 3'd1, 2'd2, 8'h00), "R8 unlock");
      res_q.push_back(3'd0); rtag_q.push_back("R8 unlock result");
      issue(2'd3, 24'h123456, 16'h0042, 1'b0);

      // R3 R4 R5 reads with different ECC codes
      do_read(24'h00ABCD, 16'h0810, 2, 8'h00, 3'd0, "R5 ecc none", 1'b1);
      do_read(24'h7F0001, 16'h0001, 0, 8'h10, 3'd1, "R5 ecc corrected", 1'b0);
      do_read(24'h000200, 16'h07FF, 1, 8'h20, 3'd2, "R5 ecc uncorrectable", 1'b0);
      do_read(24'hFFFFFF, 16'hFFFF, 0, 8'h30, 3'd2, "R5 ecc code3", 1'b0);

      // R6 program ok / fail
      for (int f = 0; f < 2; f++) begin
         push_op(wren_d(), "R6 write enable");
         push_op(d(8'h02, 24'h000123, 3'd2, 2'd0, 3'd1, 2'd2, 8'h00), "R6 load");
         push_op(d(8'h10, 24'h04A0B0, 3'd3, 2'd0, 3'd0, 2'd0, 8'h00), "R6 execute");
         push_polls(f, f ? 8'h08 : 8'h00, "R6 poll");
         res_q.push_back(f ? 3'd3 : 3'd0); rtag_q.push_back(f ? "R6 prog fail" : "R6 prog ok");
         issue(2'd1, 24'h04A0B0, 16'h0123, f == 1);
      end

      // R7 erase: bit3 ignored, bit2 fails
      for (int f = 0; f < 2; f++) begin
         push_op(wren_d(), "R7 write enable");
         push_op(d(8'hD8, 24'h0A0040, 3'd3, 2'd0, 3'd0, 2'd0, 8'h00), "R7 erase");
         push_polls(1, f ? 8'h04 : 8'h08, "R7 poll");
         res_q.push_back(f ? 3'd4 : 3'd0); rtag_q.push_back(f ? "R7 erase fail" : "R7 bit3 ignored");
         issue(2'd2, 24'h0A0040, 16'h0000, 1'b0);
      end

      // R9 timeout: 3 busy reads with limit 3, no cache read
      poll_limit = 16'd3;
      push_op(d(8'h13, 24'h000777, 3'd3, 2'd0, 3'd0, 2'd0, 8'h00), "R9 array read");
      for (int i = 0; i < 3; i++) begin push_op(poll_d(), "R9 poll"); stat_q.push_back(8'h01); end
      res_q.push_back(3'd5); rtag_q.push_back("R9 timeout");
      issue(2'd0, 24'h000777, 16'h0010, 1'b0);

      // R9 limit 0 behaves as one read
      poll_limit = 16'd0;
      push_op(wren_d(), "R9 write enable");
      push_op(d(8'hD8, 24'h000001, 3'd3, 2'd0, 3'd0, 2'd0, 8'h00), "R9 erase");
      push_op(poll_d(), "R9 poll"); stat_q.push_back(8'h01);
      res_q.push_back(3'd5); rtag_q.push_back("R9 timeout limit0");
      issue(2'd2, 24'h000001, 16'h0000, 1'b0);
      poll_limit = 16'd8;

      // R11 nothing left over
      repeat (10) @(negedge clk);
      chk("R11 no missing ops", 64'(exp_q.size()), 64'd0);
      chk("R4 status script used", 64'(stat_q.size()), 64'd0);
      chk("R10 all results seen", 64'(res_q.size()), 64'd0);
      chk("R2 idle after all", {63'd0, req_ready}, 64'd1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule